// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a byte-serial decoder for 64-bit mode instruction streams. Instruction bytes arrive one per cycle on a valid/ready input. The block consumes the legacy prefix bytes and any REX byte that lead one instruction, classifies each of them, and then captures the opcode. The opcode is either a single byte from the primary map or the 0F escape followed by its second byte. The result is a single summary record on a valid/ready output. That record holds the accumulated prefix state, the resolved operand size, the opcode bytes, and flags for the two-byte map, a mandatory-prefix form, PAUSE and a length violation.

While a record waits to be taken, the input stalls. Once the record is accepted, all state clears and scanning restarts at the first byte of the next instruction. ModR/M, SIB, displacement and immediate bytes are not examined. The byte that follows the opcode is therefore the first byte of whatever stage comes next.

Top module: `prefix_scanner`

## Requirements
- R1: Legacy prefix bytes are accepted in any order and any number of times, repeats included. out_pfx_cnt reports how many bytes, legacy or REX, preceded the opcode.
- R2: F0 sets out_lock. out_rep encodes the repeat kind as 0 for none, 1 for F2 and 2 for F3. When both appear, the one seen last decides.
- R3: out_seg encodes the segment override as 0 none, 1 for 26, 2 for 2E, 3 for 36, 4 for 3E, 5 for 64 and 6 for 65, and the last one wins. out_hint is 1 after 2E and 2 after 3E, also last wins, and other segment bytes leave it unchanged.
- R4: A byte from 40 to 4F sets out_rex, and out_rex_wrxb takes its low nibble (bit 3 W, bit 2 R, bit 1 X, bit 0 B). A legacy prefix after a REX byte discards it, clearing out_rex and out_rex_wrxb. A REX byte after another REX byte replaces it.
- R5: out_opsize is 2 (64-bit) when REX.W is in effect. Otherwise it is 1 (16-bit) when 66 was seen, and 0 (32-bit) in all other cases. So 66 has no effect on size when REX.W is set.
- R6: An opcode byte of 0F sets out_two_byte and puts the next byte in out_opc1. Otherwise out_opc1 is 0. out_mand is set when the two-byte map is combined with 66, F2 or F3.
- R7: out_pause is set only for a one-byte-map opcode 90 with out_rep equal to 2 and REX.B not in effect.
- R8: The prefix and opcode bytes may span at most MAX_LEN (15) bytes. If byte MAX_LEN is still a prefix, or is the 0F escape, the record carries out_err=1, out_pfx_cnt=MAX_LEN, and zero opcode bytes, and no further byte of that instruction is taken.
- R9: in_ready is low whenever out_valid is high, and both are idle (in_ready=1, out_valid=0) after reset.
- R10: A record held with out_ready low stays unchanged. After it is accepted, the next instruction starts with every field cleared.
- R11: out_osz and out_asz report whether 66 and 67 were seen, whatever their effect on size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Summary record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_pfx_cnt | output | CNT_W | Bytes before the opcode (MAX_LEN on error) |
| out_opc0 | output | 8 | First opcode byte |
| out_opc1 | output | 8 | Second opcode byte (two-byte map only) |
| out_two_byte | output | 1 | Opcode uses the 0F map |
| out_mand | output | 1 | Mandatory-prefix two-byte form |
| out_pause | output | 1 | Instruction is PAUSE |
| out_err | output | 1 | Length limit violated |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat kind |
| out_seg | output | 3 | Segment override code |
| out_hint | output | 2 | Branch hint code |
| out_osz | output | 1 | Operand-size override seen |
| out_asz | output | 1 | Address-size override seen |
| out_rex | output | 1 | REX in effect |
| out_rex_wrxb | output | 4 | REX W,R,X,B bits |
| out_opsize | output | 2 | Effective operand size code |

## Verification
The bench builds the block with the default MAX_LEN of 15. This makes the real limit boundaries reachable: 14 prefixes followed by a plain opcode, 14 prefixes followed by an escape, and 15 prefixes. Every byte value is swept as the lead byte. All ordered pairs drawn from the legacy prefixes plus two REX values are swept against both opcode maps. Those pairs cover last-wins, REX discard and the size rules exhaustively.

// File: rtl/pfx_scan_pkg.sv
package pfx_scan_pkg;

    typedef enum logic [1:0] {ST_SCAN = 2'd0, ST_ESC = 2'd1, ST_HOLD = 2'd2} st_e;

    typedef enum logic [1:0] {REP_NONE = 2'd0, REP_NE = 2'd1, REP_E = 2'd2} rep_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3,
        SEG_DS   = 3'd4, SEG_FS = 3'd5, SEG_GS = 3'd6
    } seg_e;

    typedef enum logic [1:0] {HINT_NONE = 2'd0, HINT_NT = 2'd1, HINT_T = 2'd2} hint_e;

    typedef enum logic [1:0] {SZ_32 = 2'd0, SZ_16 = 2'd1, SZ_64 = 2'd2} size_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0, K_LOCK = 3'd1, K_REPNE = 3'd2, K_REPE = 3'd3,
        K_OSZ  = 3'd4, K_ASZ  = 3'd5, K_SEG   = 3'd6
    } kind_e;

    localparam logic [7:0] ESC_BYTE   = 8'h0F;
    localparam logic [7:0] NOP_BYTE   = 8'h90;

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
    import pfx_scan_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic       legacy_o,
    output logic       rex_o,
    output logic       esc_o,
    output kind_e      kind_o,
    output seg_e       seg_o
);
    always_comb begin
        kind_o = K_NONE;
        seg_o  = SEG_NONE;
        case (byte_i)
            8'hF0: kind_o = K_LOCK;
            8'hF2: kind_o = K_REPNE;
            8'hF3: kind_o = K_REPE;
            8'h66: kind_o = K_OSZ;
            8'h67: kind_o = K_ASZ;
            8'h26: begin kind_o = K_SEG; seg_o = SEG_ES; end
            8'h2E: begin kind_o = K_SEG; seg_o = SEG_CS; end
            8'h36: begin kind_o = K_SEG; seg_o = SEG_SS; end
            8'h3E: begin kind_o = K_SEG; seg_o = SEG_DS; end
            8'h64: begin kind_o = K_SEG; seg_o = SEG_FS; end
            8'h65: begin kind_o = K_SEG; seg_o = SEG_GS; end
            default: ;
        endcase
        legacy_o = (kind_o != K_NONE);
        rex_o    = (byte_i[7:4] == 4'h4);
        esc_o    = (byte_i == ESC_BYTE);
    end
endmodule

// File: rtl/pfx_opsize.sv
module pfx_opsize
    import pfx_scan_pkg::*;
(
    input  logic  osz_i,
    input  logic  rex_w_i,
    output size_e size_o
);
    always_comb begin
        if (rex_w_i)    size_o = SZ_64;
        else if (osz_i) size_o = SZ_16;
        else            size_o = SZ_32;
    end
endmodule

// File: rtl/prefix_scanner.sv
module prefix_scanner
    import pfx_scan_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CNT_W-1:0] out_pfx_cnt,
    output logic [7:0]       out_opc0,
    output logic [7:0]       out_opc1,
    output logic             out_two_byte,
    output logic             out_mand,
    output logic             out_pause,
    output logic             out_err,
    output logic             out_lock,
    output logic [1:0]       out_rep,
    output logic [2:0]       out_seg,
    output logic [1:0]       out_hint,
    output logic             out_osz,
    output logic             out_asz,
    output logic             out_rex,
    output logic [3:0]       out_rex_wrxb,
    output logic [1:0]       out_opsize
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MAX_LEN - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(MAX_LEN);

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       opc0;
        logic [7:0]       opc1;
        logic             two_byte;
        logic             err;
        logic             lock;
        rep_e             rep;
        seg_e             seg;
        hint_e            hint;
        logic             osz;
        logic             asz;
        logic             rex;
        logic [3:0]       wrxb;
    } scan_t;

    scan_t s_d, s_q;

    logic  cls_legacy, cls_rex, cls_esc;
    kind_e cls_kind;
    seg_e  cls_seg;
    size_e size_res;
    logic  take, at_last;

    pfx_byte_class u_class (
        .byte_i   (in_byte),
        .legacy_o (cls_legacy),
        .rex_o    (cls_rex),
        .esc_o    (cls_esc),
        .kind_o   (cls_kind),
        .seg_o    (cls_seg)
    );

    pfx_opsize u_size (
        .osz_i   (s_q.osz),
        .rex_w_i (s_q.rex & s_q.wrxb[3]),
        .size_o  (size_res)
    );

    always_comb begin
        s_d      = s_q;
        in_ready = (s_q.st != ST_HOLD);
        take     = in_valid && in_ready;
        at_last  = (s_q.cnt == LAST_SLOT);
        case (s_q.st)
            ST_SCAN: if (take) begin
                if (cls_legacy || cls_rex) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                    if (cls_legacy) begin
                        s_d.rex  = 1'b0;
                        s_d.wrxb = 4'h0;
                        case (cls_kind)
                            K_LOCK:  s_d.lock = 1'b1;
                            K_REPNE: s_d.rep  = REP_NE;
                            K_REPE:  s_d.rep  = REP_E;
                            K_OSZ:   s_d.osz  = 1'b1;
                            K_ASZ:   s_d.asz  = 1'b1;
                            K_SEG: begin
                                s_d.seg = cls_seg;
                                if (cls_seg == SEG_CS) s_d.hint = HINT_NT;
                                if (cls_seg == SEG_DS) s_d.hint = HINT_T;
                            end
                            default: ;
                        endcase
                    end else begin
                        s_d.rex  = 1'b1;
                        s_d.wrxb = in_byte[3:0];
                    end
                    if (at_last) begin
                        s_d.err = 1'b1;
                        s_d.st  = ST_HOLD;
                    end
                end else if (cls_esc) begin
                    if (at_last) begin
                        s_d.err = 1'b1;
                        s_d.cnt = FULL_CNT;
                        s_d.st  = ST_HOLD;
                    end else begin
                        s_d.opc0 = in_byte;
                        s_d.st   = ST_ESC;
                    end
                end else begin
                    s_d.opc0 = in_byte;
                    s_d.st   = ST_HOLD;
                end
            end
            ST_ESC: if (take) begin
                s_d.opc1     = in_byte;
                s_d.two_byte = 1'b1;
                s_d.st       = ST_HOLD;
            end
            default: if (out_ready) s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid    = (s_q.st == ST_HOLD);
    assign out_pfx_cnt  = s_q.cnt;
    assign out_opc0     = s_q.opc0;
    assign out_opc1     = s_q.opc1;
    assign out_two_byte = s_q.two_byte;
    assign out_err      = s_q.err;
    assign out_lock     = s_q.lock;
    assign out_rep      = s_q.rep;
    assign out_seg      = s_q.seg;
    assign out_hint     = s_q.hint;
    assign out_osz      = s_q.osz;
    assign out_asz      = s_q.asz;
    assign out_rex      = s_q.rex;
    assign out_rex_wrxb = s_q.wrxb;
    assign out_opsize   = size_res;
    assign out_mand     = s_q.two_byte && (s_q.osz || (s_q.rep != REP_NONE));
    assign out_pause    = !s_q.two_byte && !s_q.err && (s_q.opc0 == NOP_BYTE)
                          && (s_q.rep == REP_E) && !(s_q.rex && s_q.wrxb[0]);
endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CNT_W-1:0] out_pfx_cnt,
    input logic [7:0]       out_opc0,
    input logic [7:0]       out_opc1,
    input logic             out_two_byte,
    input logic             out_mand,
    input logic             out_pause,
    input logic             out_err,
    input logic             out_lock,
    input logic [1:0]       out_rep,
    input logic [2:0]       out_seg,
    input logic [1:0]       out_hint,
    input logic             out_osz,
    input logic             out_asz,
    input logic             out_rex,
    input logic [3:0]       out_rex_wrxb,
    input logic [1:0]       out_opsize
);
    logic [40:0] rec;
    assign rec = {8'(out_pfx_cnt), out_opc0, out_opc1, out_two_byte, out_mand, out_pause,
                  out_err, out_lock, out_rep, out_seg, out_hint, out_osz, out_asz,
                  out_rex, out_rex_wrxb, out_opsize};

    // R10
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(rec));

    // R9
    in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8
    err_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_pfx_cnt == CNT_W'(MAX_LEN) && !out_two_byte && out_opc0 == 8'h00);

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_err |-> out_pfx_cnt < CNT_W'(MAX_LEN));

    // R7
    pause_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pause |-> out_opc0 == 8'h90 && out_rep == 2'd2 && !out_two_byte);

    // R5
    wide_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_opsize == 2'd2 |-> out_rex && out_rex_wrxb[3]);

    // R6
    mand_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_mand |-> out_two_byte && out_opc0 == 8'h0F);
endmodule

bind prefix_scanner pfx_scan_chk #(.MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/prefix_scanner_tb.sv
module prefix_scanner_tb;
    localparam int LIM   = 15;
    localparam int CW    = $clog2(LIM + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [CW-1:0] out_pfx_cnt;
    logic [7:0] out_opc0, out_opc1;
    logic out_two_byte, out_mand, out_pause, out_err, out_lock, out_osz, out_asz, out_rex;
    logic [1:0] out_rep, out_hint, out_opsize;
    logic [2:0] out_seg;
    logic [3:0] out_rex_wrxb;

    always #2.5 clk = ~clk;

    prefix_scanner #(.MAX_LEN(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_pfx_cnt(out_pfx_cnt),
        .out_opc0(out_opc0), .out_opc1(out_opc1), .out_two_byte(out_two_byte),
        .out_mand(out_mand), .out_pause(out_pause), .out_err(out_err), .out_lock(out_lock),
        .out_rep(out_rep), .out_seg(out_seg), .out_hint(out_hint), .out_osz(out_osz),
        .out_asz(out_asz), .out_rex(out_rex), .out_rex_wrxb(out_rex_wrxb), .out_opsize(out_opsize)
    );

    int checks = 0;
    int fails  = 0;
    int gap    = 0;
    logic [7:0] seq [0:17];
    logic [40:0] exp_rec;
    int exp_len;

    function automatic logic [40:0] act_rec();
        return {8'(out_pfx_cnt), out_opc0, out_opc1, out_two_byte, out_mand, out_pause,
                out_err, out_lock, out_rep, out_seg, out_hint, out_osz, out_asz,
                out_rex, out_rex_wrxb, out_opsize};
    endfunction

    function automatic int seg_code(logic [7:0] b);
        case (b)
            8'h26: return 1; 8'h2E: return 2; 8'h36: return 3;
            8'h3E: return 4; 8'h64: return 5; 8'h65: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_legacy(logic [7:0] b);
        return seg_code(b) != 0 || b == 8'hF0 || b == 8'hF2 || b == 8'hF3 || b == 8'h66 || b == 8'h67;
    endfunction

    // reference walk over seq[]: fills exp_rec and exp_len
    task automatic model();
        int cnt = 0, rep = 0, seg = 0, hint = 0;
        bit lock = 0, osz = 0, asz = 0, rex = 0, two = 0, err = 0, mand, pause;
        logic [3:0] w = 0;
        logic [7:0] o0 = 0, o1 = 0;
        int sz;
        int i = 0;
        bit done = 0;
        while (!done) begin
            logic [7:0] b = seq[i];
            if (is_legacy(b) || b[7:4] == 4'h4) begin
                if (b[7:4] == 4'h4) begin rex = 1; w = b[3:0]; end
                else begin
                    rex = 0; w = 0;
                    if (b == 8'hF0) lock = 1;
                    if (b == 8'hF2) rep = 1;
                    if (b == 8'hF3) rep = 2;
                    if (b == 8'h66) osz = 1;
                    if (b == 8'h67) asz = 1;
                    if (seg_code(b) != 0) seg = seg_code(b);
                    if (b == 8'h2E) hint = 1;
                    if (b == 8'h3E) hint = 2;
                end
                cnt++;
                if (cnt == LIM) begin err = 1; done = 1; end
            end else if (b == 8'h0F) begin
                if (i == LIM - 1) begin err = 1; cnt = LIM; end
                else begin o0 = b; o1 = seq[i+1]; two = 1; i++; end
                done = 1;
            end else begin
                o0 = b; done = 1;
            end
            i++;
        end
        sz    = (rex && w[3]) ? 2 : (osz ? 1 : 0);
        mand  = two && (osz || rep != 0);
        pause = !two && !err && o0 == 8'h90 && rep == 2 && !(rex && w[0]);
        exp_len = i;
        exp_rec = {8'(cnt), o0, o1, two, mand, pause, err, lock, 2'(rep), 3'(seg), 2'(hint),
                   osz, asz, rex, w, 2'(sz)};
    endtask

    task automatic check(string req, logic [40:0] act, logic [40:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        gap++;
        if (gap % 5 == 0) @(negedge clk);
    endtask

    // drive seq[], compare the record, then release it
    task automatic run(string req, int stall);
        model();
        for (int i = 0; i < exp_len; i++) send_byte(seq[i]);
        while (!out_valid) @(negedge clk);
        check(req, act_rec(), exp_rec);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            // R10 held record, R9 input blocked
            check("R10", {act_rec(), out_valid}, {exp_rec, 1'b1});
            check("R9", {31'd0, in_ready}, 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    logic [7:0] plist [0:12];

    initial begin
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        plist = '{8'hF0, 8'hF2, 8'hF3, 8'h66, 8'h67, 8'h26, 8'h2E, 8'h36,
                  8'h3E, 8'h64, 8'h65, 8'h48, 8'h41};
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", {30'd0, in_ready, out_valid}, {30'd0, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        // every byte value as lead byte: R1 R2 R3 R4 R6 R11
        for (int b = 0; b < 256; b++) begin
            seq[0] = 8'(b); seq[1] = 8'h90; seq[2] = 8'h0F; seq[3] = 8'h10;
            run("R1", 0);
        end

        // ordered pairs against both maps: R2 R3 R4 R5 R6 R7
        for (int a = 0; a < 13; a++)
            for (int c = 0; c < 13; c++)
                for (int m = 0; m < 2; m++) begin
                    seq[0] = plist[a]; seq[1] = plist[c];
                    seq[2] = m ? 8'h0F : 8'h90; seq[3] = 8'h10;
                    run(m ? "R6" : "R5", 0);
                end

        // every REX followed by legacy: REX discarded (R4), size rule (R5)
        for (int r = 0; r < 16; r++) begin
            seq[0] = 8'(8'h40 + r); seq[1] = 8'h66; seq[2] = 8'h89;
            run("R4", 0);
            seq[0] = 8'h66; seq[1] = 8'(8'h40 + r); seq[2] = 8'h89;
            run("R5", 0);
        end

        // PAUSE forms (R7)
        seq[0] = 8'hF3; seq[1] = 8'h90; run("R7", 0);
        seq[0] = 8'hF3; seq[1] = 8'h41; seq[2] = 8'h90; run("R7", 0);
        seq[0] = 8'hF2; seq[1] = 8'hF3; seq[2] = 8'h48; seq[3] = 8'h90; run("R7", 0);

        // length boundaries: k prefixes then a plain opcode or escape (R8)
        for (int k = 0; k <= LIM; k++)
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < k; i++) seq[i] = plist[(i + k) % 13];
                seq[k] = m ? 8'h0F : 8'hC3;
                seq[k+1] = 8'hB8;
                run("R8", 0);
            end

        // stalled record then clean restart (R10)
        seq[0] = 8'hF0; seq[1] = 8'h65; seq[2] = 8'h4F; seq[3] = 8'h0F; seq[4] = 8'hB1;
        run("R10", 6);
        seq[0] = 8'h90; run("R10", 0);
        for (int i = 0; i < LIM; i++) seq[i] = 8'h67;
        run("R10", 3);
        seq[0] = 8'h0F; seq[1] = 8'h05; run("R10", 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule